// File: doc/BRIEF.md
# Two-Channel Interleaved Sample Merger

This block joins two converter channels that share one analog input into a single sample stream at twice the per-channel rate. It is driven by a master clock that runs at the combined output rate. From that clock it produces the two channel sample strobes. Both strobes come from one divide-by-two toggle register: channel A takes the inverted output and channel B takes the true output. The two strobes are therefore exactly complementary, and each channel samples on every other master cycle, half a period away from its partner.

Each channel's data word is captured on the master edge that ends that channel's strobe cycle. A signed per-channel trim value is added to the word at capture, and the sum saturates to the data range. The trim cancels a static offset mismatch between the two converters. The captured words are then put back into time order in one output register. Each output word carries a tag that names its channel and a valid flag. The merged stream has a fixed delay, so the sample taken during master cycle n appears during cycle n+2.

Top module: `ilv_adc_merge`

## Requirements
- R1: `strobe_a_o` and `strobe_b_o` are always complementary, and each one inverts on every master clock edge, so each channel samples at half the output rate.
- R2: While reset is held, and in the first cycle after it is released, `strobe_a_o` is 1 and `strobe_b_o` is 0. Channel A therefore owns the even-numbered cycles (cycle 0 is the first cycle after reset) and channel B owns the odd-numbered cycles.
- R3: Valid output words alternate between channel A (`tag_o` = 0) and channel B (`tag_o` = 1), and the first valid word after reset is from channel A.
- R4: The channel word present during master cycle n, where that cycle belongs to the channel, appears on `word_o` during cycle n+2.
- R5: `valid_o` is 0 during reset and during cycles 0 and 1. From cycle 2 onward it is 1 on every cycle.
- R6: Each captured word is the two's-complement sum of the channel input and its signed trim (`TRIM_W` bits, sign-extended). The sum saturates to the most positive or most negative `DATA_W`-bit value.
- R7: Every channel sample appears exactly once, in the order it was taken. No sample is dropped or repeated.
- R8: A channel input that changes during a cycle owned by the other channel has no effect on the output.
- R9: Reset is asynchronous and active low. It clears `word_o`, `tag_o` and `valid_o` to 0, and the sequence restarts from channel A after reset is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at the combined output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_a_o | output | 1 | Sample strobe for channel A (inverted toggle output) |
| strobe_b_o | output | 1 | Sample strobe for channel B (true toggle output) |
| adc_a_i | input | DATA_W | Channel A data word, signed |
| adc_b_i | input | DATA_W | Channel B data word, signed |
| trim_a_i | input | TRIM_W | Signed offset trim for channel A |
| trim_b_i | input | TRIM_W | Signed offset trim for channel B |
| word_o | output | DATA_W | Merged, trimmed sample word, signed |
| tag_o | output | 1 | Channel of `word_o`: 0 = A, 1 = B |
| valid_o | output | 1 | `word_o` holds a real sample |

## Verification
Both channel inputs see one shared signal, and the bench expects to rebuild it in order, two cycles later. The stimulus is a steep ramp, a triangle wave with a different offset error on each channel that the trims cancel, and a pattern that sits near full scale with large trims of opposite sign. The ramp shows whether a sample was dropped, repeated or swapped. The triangle shows whether the wrong trim was applied to a channel. The full-scale pattern drives the sum past both the positive and the negative limit, so it checks saturation. On every cycle the channel that does not own the cycle is fed unrelated values, so any capture outside its own strobe shows up in the output. A reset in the middle of the run checks that the sequence starts again from channel A.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Channel identity carried on the tag output.
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;

endpackage

// File: rtl/ilv_phase_gen.sv
// Divide-by-two toggle register; both channel strobes come from its two outputs.
module ilv_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic strobe_a_o,
    output logic strobe_b_o
);

    typedef struct packed {
        logic tog;
    } phase_t;

    phase_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.tog = ~s_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Channel A uses the inverted output, so it owns the first cycle after reset.
    assign strobe_a_o = ~s_q.tog;
    assign strobe_b_o =  s_q.tog;

    a_r1_a_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_a_o |=> !strobe_a_o);
    a_r1_b_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_b_o |=> !strobe_b_o);

endmodule

// File: rtl/ilv_chan_cap.sv
// One channel: trims the word, saturates it and captures it on the channel's own strobe.
module ilv_chan_cap #(
    parameter int DATA_W = 12,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [TRIM_W-1:0] trim_i,
    output logic [DATA_W-1:0] word_o,
    output logic              loaded_o
);

    localparam int SUM_W = DATA_W + 1;
    localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              loaded;
    } cap_t;

    cap_t s_d, s_q;

    logic [SUM_W-1:0]  ext_data;
    logic [SUM_W-1:0]  ext_trim;
    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] sat;

    always_comb begin
        ext_data = {data_i[DATA_W-1], data_i};
        ext_trim = {{(SUM_W-TRIM_W){trim_i[TRIM_W-1]}}, trim_i};
        sum      = ext_data + ext_trim;
        if (sum[SUM_W-1] != sum[SUM_W-2]) begin
            sat = sum[SUM_W-1] ? NEG_LIM : POS_LIM;
        end else begin
            sat = sum[DATA_W-1:0];
        end

        s_d = s_q;
        if (strobe_i) begin
            s_d.word   = sat;
            s_d.loaded = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o   = s_q.word;
    assign loaded_o = s_q.loaded;

    a_r8_hold_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(word_o));

endmodule

// File: rtl/ilv_merge.sv
// Output stage: puts the two captured words back into time order.
module ilv_merge #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_i,
    input  logic [DATA_W-1:0] word_a_i,
    input  logic [DATA_W-1:0] word_b_i,
    input  logic              loaded_a_i,
    input  logic              loaded_b_i,
    output logic [DATA_W-1:0] word_o,
    output logic              tag_o,
    output logic              valid_o
);

    import ilv_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        chan_e             tag;
        logic              valid;
    } out_t;

    out_t s_d, s_q;

    // When phase_i is high, channel B is sampling, so channel A's word was
    // captured at the edge just passed and is the next word in time order.
    always_comb begin
        s_d = s_q;
        if (phase_i) begin
            s_d.word  = word_a_i;
            s_d.tag   = CH_A;
            s_d.valid = loaded_a_i;
        end else begin
            s_d.word  = word_b_i;
            s_d.tag   = CH_B;
            s_d.valid = loaded_b_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{word: '0, tag: CH_A, valid: 1'b0};
        else        s_q <= s_d;
    end

    assign word_o  = s_q.word;
    assign tag_o   = s_q.tag;
    assign valid_o = s_q.valid;

    a_r5_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
    a_r3_first_is_a: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (tag_o == CH_A));
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (tag_o != $past(tag_o)));

endmodule

// File: rtl/ilv_adc_merge.sv
module ilv_adc_merge #(
    parameter int DATA_W = 12,
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              strobe_a_o,
    output logic              strobe_b_o,
    input  logic [DATA_W-1:0] adc_a_i,
    input  logic [DATA_W-1:0] adc_b_i,
    input  logic [TRIM_W-1:0] trim_a_i,
    input  logic [TRIM_W-1:0] trim_b_i,
    output logic [DATA_W-1:0] word_o,
    output logic              tag_o,
    output logic              valid_o
);

    import ilv_pkg::*;

    logic [NUM_CH-1:0] strobe;
    logic [NUM_CH-1:0] loaded;
    logic [DATA_W-1:0] raw  [NUM_CH];
    logic [TRIM_W-1:0] trim [NUM_CH];
    logic [DATA_W-1:0] cap  [NUM_CH];

    ilv_phase_gen i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_a_o (strobe[0]),
        .strobe_b_o (strobe[1])
    );

    assign raw[0]  = adc_a_i;
    assign raw[1]  = adc_b_i;
    assign trim[0] = trim_a_i;
    assign trim[1] = trim_b_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ilv_chan_cap #(
            .DATA_W (DATA_W),
            .TRIM_W (TRIM_W)
        ) i_cap (
            .clk      (clk),
            .rst_n    (rst_n),
            .strobe_i (strobe[c]),
            .data_i   (raw[c]),
            .trim_i   (trim[c]),
            .word_o   (cap[c]),
            .loaded_o (loaded[c])
        );
    end

    ilv_merge #(
        .DATA_W (DATA_W)
    ) i_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (strobe[1]),
        .word_a_i   (cap[0]),
        .word_b_i   (cap[1]),
        .loaded_a_i (loaded[0]),
        .loaded_b_i (loaded[1]),
        .word_o     (word_o),
        .tag_o      (tag_o),
        .valid_o    (valid_o)
    );

    assign strobe_a_o = strobe[0];
    assign strobe_b_o = strobe[1];

    // R4: a channel A word on the output was sampled two cycles earlier, during A's strobe.
    a_r4_latency_a: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && tag_o == CH_A) |-> $past(strobe_a_o, 2));
    a_r4_latency_b: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && tag_o == CH_B) |-> $past(strobe_b_o, 2));

endmodule

// File: tb/test_ilv_adc_merge.sv
module test_ilv_adc_merge;

    localparam int DW = 12;
    localparam int TW = 8;
    localparam int VMAX = (1 << (DW-1)) - 1;
    localparam int VMIN = -(1 << (DW-1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strobe_a, strobe_b;
    logic [DW-1:0] adc_a = '0, adc_b = '0;
    logic [TW-1:0] trim_a = '0, trim_b = '0;
    logic [DW-1:0] word;
    logic          tag, valid;

    int checks = 0;
    int errors = 0;
    int exp_word[$];
    int exp_tag[$];

    always #5 clk = ~clk;

    ilv_adc_merge #(.DATA_W(DW), .TRIM_W(TW)) i_ilv_adc_merge (
        .clk(clk), .rst_n(rst_n),
        .strobe_a_o(strobe_a), .strobe_b_o(strobe_b),
        .adc_a_i(adc_a), .adc_b_i(adc_b),
        .trim_a_i(trim_a), .trim_b_i(trim_b),
        .word_o(word), .tag_o(tag), .valid_o(valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return v;
    endfunction

    function automatic int sig(input int pat, input int n);
        case (pat)
            0:       return ((n * 37) % 4096) - 2048;
            1:       return ((n / 2) % 2 == 0) ? 2040 : -2040;
            default: return ((n % 40) < 20) ? (n % 40) * 90 - 900 : (40 - (n % 40)) * 90 - 900;
        endcase
    endfunction

    task automatic check_reset_state(input string tagname);
        chk(valid == 1'b0, {"R9 valid in reset ", tagname}, int'(valid), 0);
        chk(word == '0,    {"R9 word in reset ", tagname}, int'(word), 0);
        chk(tag == 1'b0,   {"R9 tag in reset ", tagname}, int'(tag), 0);
        chk(strobe_a == 1'b1 && strobe_b == 1'b0, {"R2 strobes in reset ", tagname},
            int'({strobe_a, strobe_b}), 2);
    endtask

    // Called at a falling edge with reset held. Both converter stubs see one shared
    // signal plus their own offset error; the channel that does not own a cycle gets junk.
    task automatic run(input int pat, input int ncyc, input int ta, input int tb,
                       input int ma, input int mb);
        exp_word.delete();
        exp_tag.delete();
        trim_a = TW'(ta);
        trim_b = TW'(tb);
        for (int n = 0; n < ncyc; n++) begin
            if (n > 0) @(negedge clk);
            // R1/R2: channel A owns even cycles, strobes complementary
            chk(strobe_a == (n % 2 == 0), "R1 strobe_a phase", int'(strobe_a), int'(n % 2 == 0));
            chk(strobe_b == (n % 2 == 1), "R1 strobe_b phase", int'(strobe_b), int'(n % 2 == 1));
            if (n < 2) begin
                chk(valid == 1'b0, "R5 valid low before first pair", int'(valid), 0);
            end else begin
                int ew, et;
                ew = exp_word.pop_front();
                et = exp_tag.pop_front();
                chk(valid == 1'b1, "R5 valid high", int'(valid), 1);
                chk(int'(tag) == et, "R3 channel tag order", int'(tag), et);
                chk(int'($signed(word)) == ew, "R4 R6 R7 R8 merged word", int'($signed(word)), ew);
            end
            if (n == 0) rst_n = 1'b1;
            begin
                int v, junk;
                junk = ((n * 613 + 91) % 4096) - 2048;
                if (n % 2 == 0) begin
                    v = clampv(sig(pat, n) + ma);
                    adc_a = DW'(v);
                    adc_b = DW'(junk);
                    exp_word.push_back(clampv(v + ta));
                    exp_tag.push_back(0);
                end else begin
                    v = clampv(sig(pat, n) + mb);
                    adc_b = DW'(v);
                    adc_a = DW'(junk);
                    exp_word.push_back(clampv(v + tb));
                    exp_tag.push_back(1);
                end
            end
        end
        // Mid-run reset: outputs clear at once and the next run restarts from channel A.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("after run");
        @(negedge clk);
        check_reset_state("held");
    endtask

    initial begin : watchdog
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_reset_state("initial");
        // R7 ramp: a dropped, repeated or swapped sample breaks the sequence
        run(0, 300, 5, -3, 0, 0);
        // R6 per-channel mismatch cancelled by opposite trims
        run(2, 300, -20, 15, 20, -15);
        // R6 saturation at both limits
        run(1, 200, 100, -100, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule